// File: doc/BRIEF.md
# Exception Entry and Reset Sequencer

This block performs the hardware side of reset and exception handling for a small 32-bit core. It masters a single-word memory port and a port into the core's register file, and the core stalls while `busy_o` is high. After reset it loads the main stack pointer and the starting program counter from the bottom of memory.

When the core presents an accepted exception, the block builds an eight-word frame on a full-descending stack and enters handler mode. It loads the link register with a return code, sets the status fields and jumps through the vector for that exception number. When handler code writes one of the return codes to the program counter, the block unwinds the frame and restores the interrupted context.

The block also holds the composite status word. The core updates the condition flags through a write port. The block fills the exception-number field and the instruction-state bit, and saves and restores the whole word with the frame.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block reads word address 0x00 into R13 (bits [1:0] cleared), then reads 0x04 into R15 with bit 0 cleared. It ends idle in thread mode with the exception-number field 0 and the T bit (bit 24) set.
- R2: On entry R13 drops by 32 before any store. The frame is stored from the new R13 upward in the order R0, R1, R2, R3, R12, R14, R15, status word, one word per 4 bytes.
- R3: The status word is stored and shown on `xpsr_o` with flags N,Z,C,V at bits 31..28, T at bit 24, the exception number at bits 5..0 and all other bits zero.
- R4: After entry `handler_o` is 1, bits 5..0 hold the exception number and T is 1. R14 is 0xFFFFFFF9 if entry came from thread mode and 0xFFFFFFF1 if it came from handler mode.
- R5: The handler address is read from word address number*4, and R15 receives it with bit 0 cleared.
- R6: In handler mode, a write of 0xFFFFFFF9 or 0xFFFFFFF1 through `pc_wr_i` reads the eight frame words from R13 upward in the R2 order. It restores R0..R3, R12, R14, R15 (bit 0 cleared) and the status word, adds 32 to R13, and sets thread mode for 0xFFFFFFF9 or handler mode for 0xFFFFFFF1.
- R7: In thread mode any value written through `pc_wr_i`, including a return code, is ignored: no memory access starts and `busy_o` stays 0.
- R8: In handler mode any other value with bits [31:4] all ones starts a HardFault entry: a full frame push, exception number 3 and a vector read at 0x0C.
- R9: A fetched vector with bit 0 clear redirects to the HardFault vector at 0x0C with exception number 3 and no further push. If the bad vector was HardFault's own, `lockup_o` goes high, `busy_o` stays high and no further memory request is made until reset.
- R10: When a return code and an exception request arrive in the same idle cycle, the return is performed first. The request is acknowledged only after the unstacking has finished.
- R11: `exc_ack_o` is a single-cycle pulse given only when an entry starts from idle, and `busy_o` is high throughout every sequence.
- R12: While idle, `flags_we_i` loads `flags_i` into bits 31..28 of the status word by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request from the priority logic, held until acknowledged |
| exc_num_i | input | 6 | Exception number of the request |
| exc_ack_o | output | 1 | Request accepted, one-cycle pulse |
| pc_wr_i | input | 1 | Core writes R15 by register branch or pop |
| pc_val_i | input | 32 | Value written to R15 |
| flags_we_i | input | 1 | Condition flag update strobe |
| flags_i | input | 4 | New N,Z,C,V flags |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data, combinational |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| busy_o | output | 1 | Sequence in progress; core must stall |
| handler_o | output | 1 | 1 in handler mode, 0 in thread mode |
| xpsr_o | output | 32 | Composite status word |
| lockup_o | output | 1 | Unrecoverable fault on the HardFault vector |

## Verification
The return path and the entry path can both be triggered in one idle cycle, when handler code writes a return code while a new request is pending. The bench raises `pc_wr_i` and `exc_req_i` on the same edge and confirms that no acknowledge appears then. It then waits for the acknowledge and checks that R13 is already back at its pre-entry value and thread mode is restored at that moment. Finally it checks that the new frame and LR code reflect an entry from thread mode.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned XLEN        = 32;
  localparam int unsigned NUM_W       = 6;
  localparam int unsigned RF_AW       = 4;
  localparam int unsigned FLAG_W      = 4;
  localparam int unsigned FRAME_WORDS = 8;
  localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
  localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(FRAME_WORDS * 4);

  localparam logic [XLEN-1:0] RET_TO_THREAD  = 32'hFFFF_FFF9;
  localparam logic [XLEN-1:0] RET_TO_HANDLER = 32'hFFFF_FFF1;
  localparam logic [NUM_W-1:0] HARDFAULT_NUM = 6'd3;

  localparam logic [RF_AW-1:0] REG_SP = 4'd13;
  localparam logic [RF_AW-1:0] REG_LR = 4'd14;
  localparam logic [RF_AW-1:0] REG_PC = 4'd15;

  typedef enum logic [3:0] {
    ST_BOOT_SP,
    ST_BOOT_PC,
    ST_IDLE,
    ST_ENT_SP,
    ST_PUSH,
    ST_ENT_UPD,
    ST_VEC,
    ST_RET_SP,
    ST_POP,
    ST_RET_FIN,
    ST_LOCK
  } seq_state_e;
endpackage

// File: rtl/exc_frame_map.sv
module exc_frame_map
  import exc_seq_pkg::*;
(
  input  logic [IDX_W-1:0] slot_i,
  output logic [RF_AW-1:0] reg_o,
  output logic             psr_slot_o
);
  always_comb begin
    psr_slot_o = 1'b0;
    unique case (slot_i)
      3'd0:    reg_o = 4'd0;
      3'd1:    reg_o = 4'd1;
      3'd2:    reg_o = 4'd2;
      3'd3:    reg_o = 4'd3;
      3'd4:    reg_o = 4'd12;
      3'd5:    reg_o = REG_LR;
      3'd6:    reg_o = REG_PC;
      default: begin
        reg_o      = 4'd0;
        psr_slot_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
  import exc_seq_pkg::*;
(
  input  logic            pc_wr_i,
  input  logic [XLEN-1:0] pc_val_i,
  input  logic            handler_i,
  output logic            ret_ok_o,
  output logic            ret_bad_o,
  output logic            to_handler_o
);
  logic magic;

  assign magic        = pc_wr_i & handler_i & (&pc_val_i[XLEN-1:4]);
  assign to_handler_o = (pc_val_i[3:0] == RET_TO_HANDLER[3:0]);
  assign ret_ok_o     = magic & (to_handler_o | (pc_val_i[3:0] == RET_TO_THREAD[3:0]));
  assign ret_bad_o    = magic & ~ret_ok_o;
endmodule

// File: rtl/exc_psr_reg.sv
module exc_psr_reg
  import exc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flags_we_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              enter_i,
  input  logic [NUM_W-1:0]  enter_num_i,
  input  logic              pop_i,
  input  logic [FLAG_W-1:0] pop_flags_i,
  input  logic              pop_t_i,
  input  logic [NUM_W-1:0]  pop_num_i,
  input  logic              mode_we_i,
  input  logic              mode_handler_i,
  output logic [XLEN-1:0]   psr_o,
  output logic              handler_o
);
  logic [FLAG_W-1:0] flags_q;
  logic              t_q;
  logic [NUM_W-1:0]  num_q;
  logic              handler_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      t_q       <= 1'b1;
      num_q     <= '0;
      handler_q <= 1'b0;
    end else begin
      if (enter_i) begin
        num_q     <= enter_num_i;
        t_q       <= 1'b1;
        handler_q <= 1'b1;
      end else begin
        if (pop_i) begin
          flags_q <= pop_flags_i;
          t_q     <= pop_t_i;
          num_q   <= pop_num_i;
        end else if (flags_we_i) begin
          flags_q <= flags_i;
        end
        if (mode_we_i) handler_q <= mode_handler_i;
      end
    end
  end

  assign psr_o     = {flags_q, 3'b000, t_q, {(XLEN-8-NUM_W){1'b0}}, num_q};
  assign handler_o = handler_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [NUM_W-1:0]  exc_num_i,
  output logic              exc_ack_o,
  input  logic              pc_wr_i,
  input  logic [XLEN-1:0]   pc_val_i,
  input  logic              flags_we_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [RF_AW-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  output logic              rf_we_o,
  output logic [RF_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              busy_o,
  output logic              handler_o,
  output logic [XLEN-1:0]   xpsr_o,
  output logic              lockup_o
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  slot_q, slot_d;
  logic [XLEN-1:0]   base_q, base_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic              ret_hdl_q, ret_hdl_d;

  logic [RF_AW-1:0]  slot_reg;
  logic              slot_psr;
  logic              ret_ok, ret_bad, ret_to_hdl;
  logic              psr_enter, psr_pop, psr_mode_we, psr_flags_we;
  logic [NUM_W-1:0]  psr_enter_num;
  logic [XLEN-1:0]   slot_addr;
  logic              vec_good;

  exc_frame_map u_map (
    .slot_i     (slot_q),
    .reg_o      (slot_reg),
    .psr_slot_o (slot_psr)
  );

  exc_ret_decode u_ret (
    .pc_wr_i      (pc_wr_i),
    .pc_val_i     (pc_val_i),
    .handler_i    (handler_o),
    .ret_ok_o     (ret_ok),
    .ret_bad_o    (ret_bad),
    .to_handler_o (ret_to_hdl)
  );

  exc_psr_reg u_psr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flags_we_i     (psr_flags_we),
    .flags_i        (flags_i),
    .enter_i        (psr_enter),
    .enter_num_i    (psr_enter_num),
    .pop_i          (psr_pop),
    .pop_flags_i    (mem_rdata_i[XLEN-1:XLEN-FLAG_W]),
    .pop_t_i        (mem_rdata_i[24]),
    .pop_num_i      (mem_rdata_i[NUM_W-1:0]),
    .mode_we_i      (psr_mode_we),
    .mode_handler_i (ret_hdl_q),
    .psr_o          (xpsr_o),
    .handler_o      (handler_o)
  );

  assign slot_addr = base_q + {{(XLEN-IDX_W-2){1'b0}}, slot_q, 2'b00};
  assign vec_good  = mem_rdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BOOT_SP;
      slot_q    <= '0;
      base_q    <= '0;
      num_q     <= '0;
      ret_hdl_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      slot_q    <= slot_d;
      base_q    <= base_d;
      num_q     <= num_d;
      ret_hdl_q <= ret_hdl_d;
    end
  end

  always_comb begin
    state_d       = state_q;
    slot_d        = slot_q;
    base_d        = base_q;
    num_d         = num_q;
    ret_hdl_d     = ret_hdl_q;
    exc_ack_o     = 1'b0;
    mem_req_o     = 1'b0;
    mem_we_o      = 1'b0;
    mem_addr_o    = '0;
    mem_wdata_o   = '0;
    rf_raddr_o    = REG_SP;
    rf_we_o       = 1'b0;
    rf_waddr_o    = REG_SP;
    rf_wdata_o    = '0;
    psr_enter     = 1'b0;
    psr_enter_num = num_q;
    psr_pop       = 1'b0;
    psr_mode_we   = 1'b0;
    psr_flags_we  = 1'b0;

    unique case (state_q)
      ST_BOOT_SP: begin
        mem_req_o  = 1'b1;
        mem_addr_o = 32'h0000_0000;
        if (mem_ack_i) begin
          rf_we_o    = 1'b1;
          rf_waddr_o = REG_SP;
          rf_wdata_o = {mem_rdata_i[XLEN-1:2], 2'b00};
          state_d    = ST_BOOT_PC;
        end
      end

      ST_BOOT_PC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = 32'h0000_0004;
        if (mem_ack_i) begin
          if (vec_good) begin
            rf_we_o    = 1'b1;
            rf_waddr_o = REG_PC;
            rf_wdata_o = {mem_rdata_i[XLEN-1:1], 1'b0};
            state_d    = ST_IDLE;
          end else begin
            psr_enter     = 1'b1;
            psr_enter_num = HARDFAULT_NUM;
            num_d         = HARDFAULT_NUM;
            state_d       = ST_VEC;
          end
        end
      end

      ST_IDLE: begin
        psr_flags_we = flags_we_i;
        if (ret_ok) begin
          // return wins; a pending request waits for the unstack
          ret_hdl_d = ret_to_hdl;
          state_d   = ST_RET_SP;
        end else if (ret_bad) begin
          num_d   = HARDFAULT_NUM;
          state_d = ST_ENT_SP;
        end else if (exc_req_i) begin
          exc_ack_o = 1'b1;
          num_d     = exc_num_i;
          state_d   = ST_ENT_SP;
        end
      end

      ST_ENT_SP: begin
        rf_raddr_o = REG_SP;
        rf_we_o    = 1'b1;
        rf_waddr_o = REG_SP;
        rf_wdata_o = rf_rdata_i - FRAME_BYTES;
        base_d     = rf_rdata_i - FRAME_BYTES;
        slot_d     = '0;
        state_d    = ST_PUSH;
      end

      ST_PUSH: begin
        rf_raddr_o  = slot_reg;
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_addr;
        mem_wdata_o = slot_psr ? xpsr_o : rf_rdata_i;
        if (mem_ack_i) begin
          if (slot_q == LAST_SLOT) state_d = ST_ENT_UPD;
          else slot_d = slot_q + 1'b1;
        end
      end

      ST_ENT_UPD: begin
        rf_we_o    = 1'b1;
        rf_waddr_o = REG_LR;
        rf_wdata_o = handler_o ? RET_TO_HANDLER : RET_TO_THREAD;
        psr_enter  = 1'b1;
        state_d    = ST_VEC;
      end

      ST_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {{(XLEN-NUM_W-2){1'b0}}, num_q, 2'b00};
        if (mem_ack_i) begin
          if (vec_good) begin
            rf_we_o    = 1'b1;
            rf_waddr_o = REG_PC;
            rf_wdata_o = {mem_rdata_i[XLEN-1:1], 1'b0};
            state_d    = ST_IDLE;
          end else if (num_q == HARDFAULT_NUM) begin
            state_d = ST_LOCK;
          end else begin
            psr_enter     = 1'b1;
            psr_enter_num = HARDFAULT_NUM;
            num_d         = HARDFAULT_NUM;
          end
        end
      end

      ST_RET_SP: begin
        rf_raddr_o = REG_SP;
        base_d     = rf_rdata_i;
        slot_d     = '0;
        state_d    = ST_POP;
      end

      ST_POP: begin
        mem_req_o  = 1'b1;
        mem_addr_o = slot_addr;
        if (mem_ack_i) begin
          if (slot_psr) begin
            psr_pop = 1'b1;
          end else begin
            rf_we_o    = 1'b1;
            rf_waddr_o = slot_reg;
            rf_wdata_o = (slot_reg == REG_PC) ? {mem_rdata_i[XLEN-1:1], 1'b0} : mem_rdata_i;
          end
          if (slot_q == LAST_SLOT) state_d = ST_RET_FIN;
          else slot_d = slot_q + 1'b1;
        end
      end

      ST_RET_FIN: begin
        rf_we_o     = 1'b1;
        rf_waddr_o  = REG_SP;
        rf_wdata_o  = base_q + FRAME_BYTES;
        psr_mode_we = 1'b1;
        state_d     = ST_IDLE;
      end

      ST_LOCK: state_d = ST_LOCK;

      default: state_d = ST_LOCK;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign lockup_o = (state_q == ST_LOCK);
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exc_req_i,
  input logic              exc_ack_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [XLEN-1:0]   mem_addr_o,
  input logic              rf_we_o,
  input logic [RF_AW-1:0]  rf_waddr_o,
  input logic [XLEN-1:0]   rf_wdata_o,
  input logic              busy_o,
  input logic              handler_o,
  input logic              lockup_o
);
  // R11
  ack_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ack_o |=> !exc_ack_o);

  // R11
  ack_starts_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ack_o |=> busy_o);

  // R10
  ack_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ack_o |-> (!busy_o && exc_req_i));

  // R7
  thread_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !handler_o && !exc_req_i) |=> !busy_o);

  // R7
  idle_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  // R9
  lockup_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockup_o |=> (lockup_o && busy_o && !mem_req_o));

  // R5
  pc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == REG_PC) |-> !rf_wdata_o[0]);

  // R2
  word_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R11
  write_is_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .exc_req_i  (exc_req_i),
  .exc_ack_o  (exc_ack_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .rf_wdata_o (rf_wdata_o),
  .busy_o     (busy_o),
  .handler_o  (handler_o),
  .lockup_o   (lockup_o)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam logic [31:0] RT = 32'hFFFF_FFF9;
  localparam logic [31:0] RH = 32'hFFFF_FFF1;
  localparam int NTAB = 7;
  localparam logic [5:0] NUM_TAB [NTAB] = '{6'd2, 6'd3, 6'd11, 6'd14, 6'd15, 6'd21, 6'd47};
  localparam logic [7:0] VEC_TAB [NTAB] = '{8'h08, 8'h0C, 8'h2C, 8'h38, 8'h3C, 8'h54, 8'hBC};
  localparam logic [3:0] RIDX [7] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd12, 4'd14, 4'd15};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        exc_req = 1'b0;
  logic [5:0]  exc_num = '0;
  logic        exc_ack;
  logic        pc_wr = 1'b0;
  logic [31:0] pc_val = '0;
  logic        flags_we = 1'b0;
  logic [3:0]  flags = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we, busy, handler, lockup;
  logic [31:0] xpsr;

  logic [31:0] mem [256];
  logic [31:0] rf [16];
  logic        tb_mem_we = 1'b0;
  logic [7:0]  tb_mem_a = '0;
  logic [31:0] tb_mem_d = '0;
  logic        tb_rf_we = 1'b0;
  logic [3:0]  tb_rf_a = '0;
  logic [31:0] tb_rf_d = '0;

  int total = 0;
  int bad = 0;

  exc_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_req_i(exc_req), .exc_num_i(exc_num), .exc_ack_o(exc_ack),
    .pc_wr_i(pc_wr), .pc_val_i(pc_val),
    .flags_we_i(flags_we), .flags_i(flags),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .busy_o(busy), .handler_o(handler), .xpsr_o(xpsr), .lockup_o(lockup)
  );

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (tb_mem_we) mem[tb_mem_a] <= tb_mem_d;
    else if (rst_n && mem_req && mem_we && !mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
    if (!rst_n) mem_ack <= 1'b0;
    else mem_ack <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[9:2]];
    if (tb_rf_we) rf[tb_rf_a] <= tb_rf_d;
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  function automatic logic [31:0] psr_w(input logic [3:0] f, input logic [5:0] n);
    return {f, 3'b000, 1'b1, 18'b0, n};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke_mem(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); tb_mem_we = 1'b1; tb_mem_a = a; tb_mem_d = d;
    @(negedge clk); tb_mem_we = 1'b0;
  endtask

  task automatic poke_rf(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); tb_rf_we = 1'b1; tb_rf_a = a; tb_rf_d = d;
    @(negedge clk); tb_rf_we = 1'b0;
  endtask

  task automatic set_flags(input logic [3:0] f);
    @(negedge clk); flags_we = 1'b1; flags = f;
    @(negedge clk); flags_we = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic take(input logic [5:0] n);
    @(negedge clk); exc_req = 1'b1; exc_num = n;
    #1 check("R11 ack on accept", {31'b0, exc_ack}, 32'd1);
    @(negedge clk);
    check("R11 ack one cycle", {31'b0, exc_ack}, 32'd0);
    exc_req = 1'b0;
    wait_done();
  endtask

  task automatic do_ret(input logic [31:0] code);
    @(negedge clk); pc_wr = 1'b1; pc_val = code;
    @(negedge clk); pc_wr = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // preload while in reset
    poke_mem(8'd0, 32'h0000_0400);
    poke_mem(8'd1, 32'h0000_0101);
    for (int k = 2; k < 48; k++) poke_mem(8'(k), 32'h1000 + 32'(k * 16) + 32'd1);
    for (int k = 0; k < 16; k++) poke_rf(4'(k), 32'h0);
    check("R1 reset handler_o", {31'b0, handler}, 32'd0);
    check("R1 reset lockup_o", {31'b0, lockup}, 32'd0);
    check("R1 reset no write", {31'b0, mem_we}, 32'd0);

    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    wait_done();
    check("R1 sp loaded", rf[13], 32'h0000_0400);
    check("R1 pc loaded", rf[15], 32'h0000_0100);
    check("R1 thread mode", {31'b0, handler}, 32'd0);
    check("R1 psr after reset", xpsr, psr_w(4'h0, 6'd0));

    // table walk: entry and return for each exception number
    for (int i = 0; i < NTAB; i++) begin
      logic [5:0] n;
      n = NUM_TAB[i];
      for (int r = 0; r < 6; r++) poke_rf(RIDX[r], 32'hA000_0000 | (32'(n) << 8) | 32'(RIDX[r]));
      poke_rf(4'd15, 32'h2000 + 32'(n) * 4);
      set_flags(n[3:0]);
      check("R12 flags visible", {28'b0, xpsr[31:28]}, {28'b0, n[3:0]});
      take(n);
      check("R2 sp lowered", rf[13], 32'h0000_03E0);
      for (int k = 0; k < 7; k++)
        check("R2 frame word", mem[8'hF8 + 8'(k)],
              (k == 6) ? 32'h2000 + 32'(n) * 4 : (32'hA000_0000 | (32'(n) << 8) | 32'(RIDX[k])));
      check("R3 stacked psr", mem[8'hFF], psr_w(n[3:0], 6'd0));
      check("R5 handler pc", rf[15], 32'h1000 + 32'(VEC_TAB[i]) * 4);
      check("R4 lr thread code", rf[14], RT);
      check("R4 psr in handler", xpsr, psr_w(n[3:0], n));
      check("R4 handler mode", {31'b0, handler}, 32'd1);
      for (int r = 0; r < 4; r++) poke_rf(4'(r), 32'hDEAD_0000 | 32'(r));
      poke_rf(4'd14, 32'h0);
      set_flags(4'h0);
      do_ret(RT);
      for (int k = 0; k < 7; k++)
        check("R6 restored reg", rf[RIDX[k]],
              (k == 6) ? 32'h2000 + 32'(n) * 4 : (32'hA000_0000 | (32'(n) << 8) | 32'(RIDX[k])));
      check("R6 sp restored", rf[13], 32'h0000_0400);
      check("R6 thread again", {31'b0, handler}, 32'd0);
      check("R6 psr restored", xpsr, psr_w(n[3:0], 6'd0));
    end

    // R4 nested entry and handler-mode return
    set_flags(4'h0);
    poke_rf(4'd15, 32'h2222);
    take(6'd15);
    poke_rf(4'd15, 32'h3334);
    take(6'd21);
    check("R4 nested lr code", rf[14], RH);
    check("R2 nested sp", rf[13], 32'h0000_03C0);
    check("R3 nested stacked psr", mem[8'hF7], psr_w(4'h0, 6'd15));
    check("R2 nested stacked lr", mem[8'hF5], RT);
    do_ret(RH);
    check("R6 back in handler", {31'b0, handler}, 32'd1);
    check("R6 outer number", {26'b0, xpsr[5:0]}, 32'd15);
    check("R6 outer sp", rf[13], 32'h0000_03E0);
    check("R6 outer lr", rf[14], RT);
    check("R6 outer pc", rf[15], 32'h3334);
    do_ret(RT);
    check("R6 nested unwind sp", rf[13], 32'h0000_0400);

    // R7 return code in thread mode is ignored
    @(negedge clk); pc_wr = 1'b1; pc_val = RT;
    #1 check("R7 no request", {31'b0, mem_req}, 32'd0);
    @(negedge clk); pc_wr = 1'b0;
    check("R7 not busy", {31'b0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    check("R7 sp untouched", rf[13], 32'h0000_0400);
    check("R7 still thread", {31'b0, handler}, 32'd0);

    // R8 invalid return code
    take(6'd14);
    do_ret(32'hFFFF_FFF5);
    check("R8 fault number", {26'b0, xpsr[5:0]}, 32'd3);
    check("R8 fault pc", rf[15], 32'h0000_1030);
    check("R8 fault sp", rf[13], 32'h0000_03C0);
    check("R8 fault lr", rf[14], RH);
    check("R8 stacked psr", mem[8'hF7], psr_w(4'h0, 6'd14));
    do_ret(RH);
    check("R8 unwind to 14", {26'b0, xpsr[5:0]}, 32'd14);
    do_ret(RT);

    // R9 bad vector redirects without a second push
    poke_mem(8'd11, 32'h0000_3000);
    take(6'd11);
    check("R9 redirect number", {26'b0, xpsr[5:0]}, 32'd3);
    check("R9 redirect pc", rf[15], 32'h0000_1030);
    check("R9 single frame", rf[13], 32'h0000_03E0);
    check("R9 not locked", {31'b0, lockup}, 32'd0);
    do_ret(RT);
    poke_mem(8'd11, 32'h0000_10B1);

    // R10 return and request in the same cycle
    take(6'd14);
    @(negedge clk); pc_wr = 1'b1; pc_val = RT; exc_req = 1'b1; exc_num = 6'd15;
    #1 check("R10 no ack while returning", {31'b0, exc_ack}, 32'd0);
    @(negedge clk); pc_wr = 1'b0;
    for (int n = 0; n < 200 && !exc_ack; n++) @(negedge clk);
    check("R10 ack after unstack", {31'b0, exc_ack}, 32'd1);
    check("R10 sp restored first", rf[13], 32'h0000_0400);
    check("R10 thread before entry", {31'b0, handler}, 32'd0);
    @(negedge clk); exc_req = 1'b0;
    wait_done();
    check("R10 new entry number", {26'b0, xpsr[5:0]}, 32'd15);
    check("R10 new entry lr", rf[14], RT);
    check("R10 new entry sp", rf[13], 32'h0000_03E0);
    do_ret(RT);

    // R9 lockup on bad HardFault vector
    poke_mem(8'd3, 32'h0000_2000);
    poke_mem(8'd11, 32'h0000_3000);
    @(negedge clk); exc_req = 1'b1; exc_num = 6'd11;
    @(negedge clk); exc_req = 1'b0;
    repeat (60) @(negedge clk);
    check("R9 lockup set", {31'b0, lockup}, 32'd1);
    check("R9 busy held", {31'b0, busy}, 32'd1);
    check("R9 no request", {31'b0, mem_req}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule